// File: doc/BRIEF.md
# Power-Good Supervisor With Hiccup Restart

This block decides when a group of step-down converters may run and when their shared power-good flag may be raised. A single enable request, gated by a chip-wide fault-free flag, starts every converter at the same moment and opens a soft-start window. Each output has two comparator flags: one reporting "below 85 % of nominal" (undervoltage) and one reporting "above 90 % of nominal" (in regulation). Both flags are filtered by a deglitcher before the controller acts on them. All time intervals are counted in pulses of a `tick` input. Each interval length is a parameter.

The power-good output is active high. It rises only after three conditions hold: the soft-start window has finished, every output has been filtered as in regulation, and a long reset interval has run without interruption while all outputs stayed in regulation. A filtered undervoltage on any output, outside the soft-start window, drops power-good at once. The converters keep switching for a hiccup on-interval and then stop. After a hiccup off-interval they all restart together through a new soft-start.

The controller is one state machine with these states:
- `ST_OFF`: converters off.
- `ST_RAMP`: soft-start running.
- `ST_SETTLE`: waiting for regulation and for the reset interval.
- `ST_GOOD`: power-good raised.
- `ST_UV_RUN`: hiccup on-interval.
- `ST_UV_REST`: hiccup off-interval.

Its transitions are:
- Any state goes to `ST_OFF` when the request or the fault-free flag is low.
- OFF→RAMP when the request is active.
- RAMP→SETTLE when the soft-start count expires.
- SETTLE→GOOD when the reset count expires with all outputs in regulation.
- SETTLE→UV_RUN and GOOD→UV_RUN on a filtered undervoltage.
- UV_RUN→UV_REST when the on-count expires.
- UV_REST→RAMP when the off-count expires.

Top module: `pwrgood_supervisor`

## Requirements
- R1: When `enable_in` and `fault_free` are both high, `conv_en` and `softstart` rise together. `softstart` stays high for SS_TICKS ticks and then falls while `conv_en` stays high.
- R2: `pgood` is high only in state GOOD. It rises only after soft-start has ended, every `ok_raw` bit has been filtered high, and RP_TICKS ticks have then passed with all outputs filtered in regulation.
- R3: A filtered undervoltage on any channel (a `uv_raw` bit at 1 means that output is below 85 %) clears `pgood` on the next clock.
- R4: A `uv_raw` or `ok_raw` change that lasts fewer than DG_TICKS ticks has no effect. A change held for DG_TICKS ticks reaches the controller, on rising and on falling edges alike.
- R5: After an undervoltage is accepted, `conv_en` stays high for HON_TICKS ticks and then falls.
- R6: After HON_TICKS ticks off, and a further HOFF_TICKS ticks, `conv_en` and `softstart` rise again together for all channels.
- R7: During soft-start a filtered undervoltage is ignored: `conv_en` and `softstart` stay high.
- R8: If all-in-regulation is lost before the reset interval ends, that interval restarts from zero once regulation returns.
- R9: `enable_in` low or `fault_free` low clears `conv_en`, `softstart` and `pgood` on the next clock edge and clears every timer and filter.
- R10: After reset, `conv_en`, `softstart` and `pgood` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse; every interval is counted in these |
| enable_in | input | 1 | Request to run the converters |
| fault_free | input | 1 | High while no chip-level fault is present |
| uv_raw | input | NUM_CH | Per-channel undervoltage comparator flag, 1 = below 85 % |
| ok_raw | input | NUM_CH | Per-channel regulation comparator flag, 1 = above 90 % |
| conv_en | output | 1 | Common enable for all converters |
| softstart | output | 1 | High while the soft-start window is open |
| pgood | output | 1 | Power-good, active high |

## Verification
The bench builds the block with a tick every 8 clocks and with these intervals:
- SS_TICKS = 8
- DG_TICKS = 3
- RP_TICKS = 12
- HON_TICKS = 5
- HOFF_TICKS = 7

With these values a whole hiccup cycle fits in a few hundred clocks. The deglitch interval is short enough that a filter still holding an undervoltage overlaps the soft-start window, which exercises the mask. The reset interval is long enough that a regulation loss can start and end inside it, so a restarting timer can be told apart from one that only pauses. Every edge is checked a tick before and a tick after the point the requirement predicts.

// File: rtl/pwrgood_pkg.sv
package pwrgood_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RAMP,
        ST_SETTLE,
        ST_GOOD,
        ST_UV_RUN,
        ST_UV_REST
    } pg_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pg_deglitch.sv
// Passes a raw flag through only after it has differed from the filtered
// value for HOLD_TICKS consecutive ticks; shorter excursions are dropped.
module pg_deglitch #(
    parameter int CNT_W      = 8,
    parameter int HOLD_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic raw,
    output logic filt
);
    localparam logic [CNT_W-1:0] HOLD_L = CNT_W'(HOLD_TICKS);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (clr) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == HOLD_L - 1'b1) begin
                filt <= raw;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pg_tick_timer.sv
// Saturating tick counter; expired once limit ticks were seen since clear.
module pg_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && (cnt < limit)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= limit);

endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
    import pwrgood_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active,
    input  logic      all_ok,
    input  logic      any_uv,
    input  logic      phase_done,
    input  logic      rp_done,
    output pg_state_t state,
    output logic      phase_clr,
    output logic      rp_clr,
    output logic      conv_en,
    output logic      softstart,
    output logic      pgood
);
    pg_state_t nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     nxt = ST_RAMP;
                ST_RAMP:    if (phase_done) nxt = ST_SETTLE;
                ST_SETTLE: begin
                    if (any_uv)                 nxt = ST_UV_RUN;
                    else if (all_ok && rp_done) nxt = ST_GOOD;
                end
                ST_GOOD:    if (any_uv)     nxt = ST_UV_RUN;
                ST_UV_RUN:  if (phase_done) nxt = ST_UV_REST;
                ST_UV_REST: if (phase_done) nxt = ST_RAMP;
            endcase
        end
    end

    assign phase_clr = (nxt != state);
    assign rp_clr    = (state != ST_SETTLE) || !all_ok;

    // registered outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_en   <= 1'b0;
            softstart <= 1'b0;
            pgood     <= 1'b0;
        end else begin
            unique case (nxt)
                ST_OFF, ST_UV_REST: begin
                    conv_en <= 1'b0; softstart <= 1'b0; pgood <= 1'b0;
                end
                ST_RAMP: begin
                    conv_en <= 1'b1; softstart <= 1'b1; pgood <= 1'b0;
                end
                ST_SETTLE, ST_UV_RUN: begin
                    conv_en <= 1'b1; softstart <= 1'b0; pgood <= 1'b0;
                end
                ST_GOOD: begin
                    conv_en <= 1'b1; softstart <= 1'b0; pgood <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwrgood_supervisor.sv
module pwrgood_supervisor
    import pwrgood_pkg::*;
#(
    parameter int NUM_CH     = 3,
    parameter int SS_TICKS   = 6000,
    parameter int DG_TICKS   = 22000,
    parameter int RP_TICKS   = 2000000,
    parameter int HON_TICKS  = 24000,
    parameter int HOFF_TICKS = 30000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable_in,
    input  logic              fault_free,
    input  logic [NUM_CH-1:0] uv_raw,
    input  logic [NUM_CH-1:0] ok_raw,
    output logic              conv_en,
    output logic              softstart,
    output logic              pgood
);
    localparam int T_MAX = max_of(max_of(max_of(SS_TICKS, DG_TICKS), max_of(RP_TICKS, HON_TICKS)), HOFF_TICKS);
    localparam int CNT_W = $clog2(T_MAX + 1) + 1;

    localparam logic [CNT_W-1:0] SS_L   = CNT_W'(SS_TICKS);
    localparam logic [CNT_W-1:0] RP_L   = CNT_W'(RP_TICKS);
    localparam logic [CNT_W-1:0] HON_L  = CNT_W'(HON_TICKS);
    localparam logic [CNT_W-1:0] HOFF_L = CNT_W'(HOFF_TICKS);

    logic              active;
    logic [NUM_CH-1:0] uv_filt;
    logic [NUM_CH-1:0] ok_filt;
    logic              all_ok, any_uv;
    logic              phase_clr, rp_clr, phase_done, rp_done;
    logic [CNT_W-1:0]  phase_limit;
    pg_state_t         state;

    assign active = enable_in && fault_free;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pg_deglitch #(.CNT_W(CNT_W), .HOLD_TICKS(DG_TICKS)) u_uv_dg (
            .clk(clk), .rst_n(rst_n), .clr(!active), .tick(tick),
            .raw(uv_raw[ch]), .filt(uv_filt[ch])
        );
        pg_deglitch #(.CNT_W(CNT_W), .HOLD_TICKS(DG_TICKS)) u_ok_dg (
            .clk(clk), .rst_n(rst_n), .clr(!active), .tick(tick),
            .raw(ok_raw[ch]), .filt(ok_filt[ch])
        );
    end

    assign all_ok = &ok_filt;
    assign any_uv = |uv_filt;

    always_comb begin
        unique case (state)
            ST_RAMP:    phase_limit = SS_L;
            ST_UV_RUN:  phase_limit = HON_L;
            ST_UV_REST: phase_limit = HOFF_L;
            default:    phase_limit = SS_L;
        endcase
    end

    pg_tick_timer #(.CNT_W(CNT_W)) u_phase_tmr (
        .clk(clk), .rst_n(rst_n), .clr(phase_clr || !active), .tick(tick),
        .limit(phase_limit), .expired(phase_done)
    );

    pg_tick_timer #(.CNT_W(CNT_W)) u_reset_tmr (
        .clk(clk), .rst_n(rst_n), .clr(rp_clr || !active), .tick(tick),
        .limit(RP_L), .expired(rp_done)
    );

    pg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .all_ok(all_ok),
        .any_uv(any_uv), .phase_done(phase_done), .rp_done(rp_done),
        .state(state), .phase_clr(phase_clr), .rp_clr(rp_clr),
        .conv_en(conv_en), .softstart(softstart), .pgood(pgood)
    );

endmodule

// File: rtl/pwrgood_checker.sv
module pwrgood_checker #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_in,
    input logic              fault_free,
    input logic              conv_en,
    input logic              softstart,
    input logic              pgood,
    input logic [NUM_CH-1:0] uv_filt,
    input logic [NUM_CH-1:0] ok_filt
);
    // R1: soft-start only while converters are enabled
    p_ss_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        softstart |-> conv_en);

    // R2: power-good never during soft-start and never with converters off
    p_pg_outside_ss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> (conv_en && !softstart));

    // R2: power-good rises only after all outputs were filtered in regulation
    p_pg_rise_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(&ok_filt));

    // R3: filtered undervoltage clears power-good on the next edge
    p_uv_drops_pg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|uv_filt) |=> !pgood);

    // R9: request or fault-free low clears every output on the next edge
    p_inactive_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable_in && fault_free) |=> (!conv_en && !softstart && !pgood));
endmodule

bind pwrgood_supervisor pwrgood_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable_in(enable_in), .fault_free(fault_free),
    .conv_en(conv_en), .softstart(softstart), .pgood(pgood),
    .uv_filt(uv_filt), .ok_filt(ok_filt)
);

// File: tb/pwrgood_supervisor_test.sv
`timescale 1ns/1ps
module pwrgood_supervisor_test;
    localparam int NCH  = 3;
    localparam int SS   = 8;
    localparam int DG   = 3;
    localparam int RP   = 12;
    localparam int HON  = 5;
    localparam int HOFF = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic enable_in = 1'b0;
    logic fault_free = 1'b0;
    logic [NCH-1:0] uv_raw = '0;
    logic [NCH-1:0] ok_raw = '0;
    logic conv_en, softstart, pgood;
    logic [2:0] tdiv = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tdiv <= tdiv + 3'd1;
        tick <= (tdiv == 3'd7);
    end

    pwrgood_supervisor #(
        .NUM_CH(NCH), .SS_TICKS(SS), .DG_TICKS(DG), .RP_TICKS(RP),
        .HON_TICKS(HON), .HOFF_TICKS(HOFF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable_in(enable_in),
        .fault_free(fault_free), .uv_raw(uv_raw), .ok_raw(ok_raw),
        .conv_en(conv_en), .softstart(softstart), .pgood(pgood)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    // wait until n ticks were consumed, then settle a few clocks
    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!tick) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 conv_en after reset", conv_en, 1'b0);
        chk("R10 softstart after reset", softstart, 1'b0);
        chk("R10 pgood after reset", pgood, 1'b0);
    endtask

    task automatic t_startup();
        ok_raw = '1;
        uv_raw = '0;
        fault_free = 1'b1;
        enable_in = 1'b1;
        wait_ticks(1);
        chk("R1 conv_en at start", conv_en, 1'b1);
        chk("R1 softstart at start", softstart, 1'b1);
        wait_ticks(6);
        chk("R1 softstart before end", softstart, 1'b1);
        chk("R2 pgood low during soft-start", pgood, 1'b0);
        wait_ticks(2);
        chk("R1 softstart ended", softstart, 1'b0);
        chk("R1 conv_en after soft-start", conv_en, 1'b1);
        wait_ticks(10);
        chk("R2 pgood low before reset interval", pgood, 1'b0);
        wait_ticks(2);
        chk("R2 pgood after reset interval", pgood, 1'b1);
    endtask

    task automatic t_glitch();
        uv_raw[1] = 1'b1;
        wait_ticks(DG - 1);
        uv_raw[1] = 1'b0;
        wait_ticks(1);
        chk("R4 short undervoltage ignored", pgood, 1'b1);
        ok_raw[2] = 1'b0;
        wait_ticks(DG - 1);
        ok_raw[2] = 1'b1;
        wait_ticks(1);
        chk("R4 short regulation loss ignored", pgood, 1'b1);
    endtask

    task automatic t_hiccup();
        uv_raw[0] = 1'b1;
        wait_ticks(2);
        chk("R4 undervoltage not yet accepted", pgood, 1'b1);
        wait_ticks(1);
        chk("R3 pgood cleared on undervoltage", pgood, 1'b0);
        chk("R5 converters still running", conv_en, 1'b1);
        wait_ticks(4);
        chk("R5 on-interval not over", conv_en, 1'b1);
        wait_ticks(2);
        chk("R5 converters stopped", conv_en, 1'b0);
        wait_ticks(5);
        chk("R6 off-interval not over", conv_en, 1'b0);
        wait_ticks(2);
        chk("R6 restart conv_en", conv_en, 1'b1);
        chk("R6 restart softstart", softstart, 1'b1);
        wait_ticks(2);
        uv_raw[0] = 1'b0;
        wait_ticks(3);
        chk("R7 undervoltage masked conv_en", conv_en, 1'b1);
        chk("R7 undervoltage masked softstart", softstart, 1'b1);
        wait_ticks(16);
        chk("R7 pgood after masked ramp", pgood, 1'b1);
    endtask

    task automatic t_rp_restart();
        enable_in = 1'b0;
        @(negedge clk);
        chk("R9 enable low clears conv_en", conv_en, 1'b0);
        chk("R9 enable low clears pgood", pgood, 1'b0);
        ok_raw[0] = 1'b0;
        enable_in = 1'b1;
        wait_ticks(10);
        chk("R2 pgood waits for regulation", pgood, 1'b0);
        ok_raw[0] = 1'b1;
        wait_ticks(7);
        ok_raw[0] = 1'b0;
        wait_ticks(4);
        ok_raw[0] = 1'b1;
        wait_ticks(12);
        chk("R8 reset interval restarted", pgood, 1'b0);
        wait_ticks(5);
        chk("R8 pgood after restarted interval", pgood, 1'b1);
    endtask

    task automatic t_fault();
        fault_free = 1'b0;
        @(negedge clk);
        chk("R9 fault clears pgood", pgood, 1'b0);
        chk("R9 fault clears conv_en", conv_en, 1'b0);
        wait_ticks(2);
        chk("R9 stays off while faulted", conv_en, 1'b0);
        fault_free = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 restart after fault conv_en", conv_en, 1'b1);
        chk("R1 restart after fault softstart", softstart, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_startup();
        t_glitch();
        t_hiccup();
        t_rp_restart();
        t_fault();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule